// File: doc/BRIEF.md
# Vector Magnitude Estimator

This block estimates the length of a two-dimensional vector, sqrt(a² + b²), from two signed components. It does not take a square root. It uses a cheap piecewise-linear estimate. With x as the larger of |a| and |b| and y as the smaller, the estimate is max((x − (x>>3)) + (y>>1), x). The block spreads the work over a fixed run of clock cycles. A small controller reuses three working registers and two multi-function arithmetic units. Two fixed right shifters sit beside them.

A client drives both components, pulses start, and waits for the one-cycle done pulse. The result stays on the output until the next accepted start. While a computation runs, the block ignores start and the input buses.

Top module: `vecmag_est`

## Requirements
- R1: While reset is high and on the first cycle after it falls, done_o is 0 and result_o is 0.
- R2: When start_i is 1 on a rising edge while the block is idle, a_i and b_i are captured on that edge. done_o is 1 for exactly the cycle that follows the seventh rising edge, counting the capturing edge as the first.
- R3: At done_o, result_o equals max((x − floor(x/8)) + floor(y/2), x), where x = max(|a|,|b|) and y = min(|a|,|b|), with a and b the captured values.
- R4: The inputs a_i and b_i are 16-bit two's complement. result_o is 17 bits unsigned. An input of −32768 is treated as magnitude 32768, so a = −32768, b = 0 gives 32768, and a = b = −32768 gives 45056.
- R5: done_o is a single-cycle pulse. result_o keeps its value from the done cycle until the next accepted start.
- R6: A start_i pulse that arrives while a computation is running has no effect on the timing of done_o or on the result.
- R7: At done_o, result_o is never below x, the larger input magnitude.
- R8: Equal magnitudes are handled with x = y. For example, a = 100, b = 100 gives 138, and a = 7, b = −7 gives 10.
- R9: Changes on a_i and b_i after the capturing edge do not alter the result of the running computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a computation when idle |
| a_i | input | 16 | First component, two's complement |
| b_i | input | 16 | Second component, two's complement |
| result_o | output | 17 | Magnitude estimate, unsigned |
| done_o | output | 1 | One-cycle pulse: result_o is valid |

## Verification
Every working register is reused for several variables, so a wrong mux select or a lost write puts a stale operand into a later step. That shows up as a wrong result_o at the very next done pulse, seven cycles after start. A controller that skips or repeats a state moves done_o off its seventh-edge slot, and the bench checks that slot cycle by cycle. Register and state slips inside the run, such as a negative value after the absolute step or a minimum above the maximum, are caught by the bound checker one cycle after the faulty write.

// File: rtl/vecmag_pkg.sv
package vecmag_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_SH_MAJ = 3;
    localparam int DEF_SH_MIN = 1;

    // controller states, one per scheduled operation group
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ABS    = 3'd1,
        ST_MINMAX = 3'd2,
        ST_SHIFT  = 3'd3,
        ST_SUB    = 3'd4,
        ST_ADD    = 3'd5,
        ST_MAX    = 3'd6,
        ST_DONE   = 3'd7
    } state_e;

    // wide unit: |y|, min, add, subtract
    typedef enum logic [1:0] {
        WU_ABS = 2'd0,
        WU_MIN = 2'd1,
        WU_ADD = 2'd2,
        WU_SUB = 2'd3
    } wide_op_e;

    // narrow unit: |x|, max
    typedef enum logic {
        NU_ABS = 1'b0,
        NU_MAX = 1'b1
    } narrow_op_e;

    typedef enum logic [1:0] {
        R1_HOLD = 2'd0,
        R1_LOAD = 2'd1,
        R1_NU   = 2'd2
    } r1_src_e;

    typedef enum logic [1:0] {
        R2_HOLD = 2'd0,
        R2_LOAD = 2'd1,
        R2_WU   = 2'd2,
        R2_SHJ  = 2'd3
    } r2_src_e;

    typedef struct packed {
        r1_src_e    r1_src;
        r2_src_e    r2_src;
        logic       r3_we;
        wide_op_e   wu_op;
        narrow_op_e nu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{r1_src: R1_HOLD, r2_src: R2_HOLD,
                                    r3_we: 1'b0, wu_op: WU_ABS, nu_op: NU_ABS};

endpackage

// File: rtl/vecmag_ctrl.sv
module vecmag_ctrl
    import vecmag_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   start_i,
    output state_e state_o,
    output ctrl_t  ctrl_o,
    output logic   done_o
);

    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ABS;
            ST_ABS:    state_d = ST_MINMAX;
            ST_MINMAX: state_d = ST_SHIFT;
            ST_SHIFT:  state_d = ST_SUB;
            ST_SUB:    state_d = ST_ADD;
            ST_ADD:    state_d = ST_MAX;
            ST_MAX:    state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        ctrl_o = CTRL_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_o.r1_src = R1_LOAD;
                    ctrl_o.r2_src = R2_LOAD;
                end
            end
            ST_ABS: begin
                ctrl_o.r1_src = R1_NU;
                ctrl_o.nu_op  = NU_ABS;
                ctrl_o.r2_src = R2_WU;
                ctrl_o.wu_op  = WU_ABS;
            end
            ST_MINMAX: begin
                ctrl_o.r1_src = R1_NU;
                ctrl_o.nu_op  = NU_MAX;
                ctrl_o.r2_src = R2_WU;
                ctrl_o.wu_op  = WU_MIN;
            end
            ST_SHIFT: begin
                ctrl_o.r2_src = R2_SHJ;
                ctrl_o.r3_we  = 1'b1;
            end
            ST_SUB: begin
                ctrl_o.r2_src = R2_WU;
                ctrl_o.wu_op  = WU_SUB;
            end
            ST_ADD: begin
                ctrl_o.r2_src = R2_WU;
                ctrl_o.wu_op  = WU_ADD;
            end
            ST_MAX: begin
                ctrl_o.r1_src = R1_NU;
                ctrl_o.nu_op  = NU_MAX;
            end
            default: ctrl_o = CTRL_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign done_o  = (state_q == ST_DONE);

endmodule

// File: rtl/vecmag_narrow_unit.sv
module vecmag_narrow_unit
    import vecmag_pkg::*;
#(
    parameter int W = DEF_DATA_W + 1
) (
    input  narrow_op_e          op_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic signed [W-1:0] z_o
);

    always_comb begin
        unique case (op_i)
            NU_ABS:  z_o = x_i[W-1] ? -x_i : x_i;
            NU_MAX:  z_o = (x_i >= y_i) ? x_i : y_i;
            default: z_o = x_i;
        endcase
    end

endmodule

// File: rtl/vecmag_wide_unit.sv
module vecmag_wide_unit
    import vecmag_pkg::*;
#(
    parameter int W = DEF_DATA_W + 1
) (
    input  wide_op_e            op_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic signed [W-1:0] z_o
);

    always_comb begin
        unique case (op_i)
            WU_ABS:  z_o = y_i[W-1] ? -y_i : y_i;
            WU_MIN:  z_o = (x_i <= y_i) ? x_i : y_i;
            WU_ADD:  z_o = x_i + y_i;
            WU_SUB:  z_o = x_i - y_i;
            default: z_o = y_i;
        endcase
    end

endmodule

// File: rtl/vecmag_shifter.sv
module vecmag_shifter #(
    parameter int W  = 17,
    parameter int SH = 1
) (
    input  logic signed [W-1:0] d_i,
    output logic signed [W-1:0] q_o
);

    generate
        if (SH == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_shift
            assign q_o = d_i >>> SH;
        end
    endgenerate

endmodule

// File: rtl/vecmag_est.sv
module vecmag_est
    import vecmag_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int SH_MAJ = DEF_SH_MAJ,
    parameter int SH_MIN = DEF_SH_MIN
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W:0]   result_o,
    output logic              done_o
);

    localparam int INT_W = DATA_W + 1;

    state_e st;
    ctrl_t  ctrl;

    logic signed [INT_W-1:0] r1_q, r2_q, r3_q;
    logic signed [INT_W-1:0] nu_z, wu_x, wu_z, shj_q, shn_q;
    logic signed [INT_W-1:0] a_ext, b_ext;

    assign a_ext = {a_i[DATA_W-1], a_i};
    assign b_ext = {b_i[DATA_W-1], b_i};

    vecmag_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .state_o (st),
        .ctrl_o  (ctrl),
        .done_o  (done_o)
    );

    vecmag_narrow_unit #(.W(INT_W)) u_nu (
        .op_i (ctrl.nu_op),
        .x_i  (r1_q),
        .y_i  (r2_q),
        .z_o  (nu_z)
    );

    // the add step sums the held minor term (R3) with R2; all others read R1
    assign wu_x = (ctrl.wu_op == WU_ADD) ? r3_q : r1_q;

    vecmag_wide_unit #(.W(INT_W)) u_wu (
        .op_i (ctrl.wu_op),
        .x_i  (wu_x),
        .y_i  (r2_q),
        .z_o  (wu_z)
    );

    vecmag_shifter #(.W(INT_W), .SH(SH_MAJ)) u_shj (
        .d_i (r1_q),
        .q_o (shj_q)
    );

    vecmag_shifter #(.W(INT_W), .SH(SH_MIN)) u_shn (
        .d_i (r2_q),
        .q_o (shn_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r1_q <= '0;
            r2_q <= '0;
            r3_q <= '0;
        end else begin
            unique case (ctrl.r1_src)
                R1_LOAD: r1_q <= a_ext;
                R1_NU:   r1_q <= nu_z;
                default: r1_q <= r1_q;
            endcase
            unique case (ctrl.r2_src)
                R2_LOAD: r2_q <= b_ext;
                R2_WU:   r2_q <= wu_z;
                R2_SHJ:  r2_q <= shj_q;
                default: r2_q <= r2_q;
            endcase
            if (ctrl.r3_we) r3_q <= shn_q;
        end
    end

    assign result_o = r1_q;

endmodule

// File: rtl/vecmag_est_chk.sv
module vecmag_est_chk
    import vecmag_pkg::*;
#(
    parameter int INT_W = 17
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             done_o,
    input logic [INT_W-1:0] result_o,
    input state_e           st,
    input logic [INT_W-1:0] r1_q,
    input logic [INT_W-1:0] r2_q
);

    assert_reset_idle_R1: assert property (@(posedge clk_i)
        rst_i |=> (st == ST_IDLE && !done_o && result_o == '0));

    assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_result_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_IDLE && !start_i) |=> $stable(result_o));

    assert_busy_ignores_start_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_MINMAX) |=> (st == ST_SHIFT));

    assert_busy_chain_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_MAX) |=> done_o);

    assert_abs_nonneg_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_MINMAX) |-> (!r1_q[INT_W-1] && !r2_q[INT_W-1]));

    assert_major_minor_order_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_SHIFT) |-> (r1_q >= r2_q));

    assert_result_floor_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_DONE) |-> (result_o >= $past(r1_q) && !result_o[INT_W-1]));

endmodule

bind vecmag_est vecmag_est_chk #(.INT_W(INT_W)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .done_o   (done_o),
    .result_o (result_o),
    .st       (st),
    .r1_q     (r1_q),
    .r2_q     (r2_q)
);

// File: tb/vecmag_est_tb_top.sv
module vecmag_est_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] a_r = '0;
    logic [15:0] b_r = '0;
    logic [16:0] res;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vecmag_est dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .a_i      (a_r),
        .b_i      (b_r),
        .result_o (res),
        .done_o   (done)
    );

    // columns: a, b, expected estimate (worked by hand from R3)
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {16'd0,      16'd0,      17'd0},
        {16'd3,      16'd4,      17'd5},
        {-16'sd3,    16'd4,      17'd5},
        {16'd100,    16'd100,    17'd138},
        {16'd7,      -16'sd7,    17'd10},
        {16'h8000,   16'd0,      17'd32768},
        {16'h8000,   16'h8000,   17'd45056},
        {16'd32767,  16'd1,      17'd32767},
        {16'd1000,   -16'sd2000, 17'd2250},
        {-16'sd1,    16'd0,      17'd1},
        {16'd12,     16'd5,      17'd13},
        {16'd0,      16'h8000,   17'd32768}
    };

    function automatic logic [16:0] ref_mag(input logic [15:0] a, input logic [15:0] b);
        int ia, ib, x, y, t;
        ia = $signed(a);
        ib = $signed(b);
        if (ia < 0) ia = -ia;
        if (ib < 0) ib = -ib;
        x = (ia > ib) ? ia : ib;
        y = (ia > ib) ? ib : ia;
        t = (x - x / 8) + y / 2;
        return 17'((t > x) ? t : x);
    endfunction

    task automatic chk17(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one operation; disturb=1 pulses start and changes inputs while busy (R6, R9)
    task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                          input logic [16:0] exp, input string req, input bit disturb);
        logic [16:0] held;
        @(negedge clk);
        a_r = a;
        b_r = b;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            if (disturb && i == 2) begin
                start = 1'b1;
                a_r = ~a;
                b_r = 16'h1234;
            end
            if (disturb && i == 3) start = 1'b0;
            @(posedge clk);
            #1;
            chk1({req, " R2 done timing"}, done, (i == 6));
        end
        chk17({req, " R3 result"}, res, exp);
        held = res;
        @(posedge clk);
        #1;
        chk1({req, " R5 done single pulse"}, done, 1'b0);
        @(posedge clk);
        #1;
        chk17({req, " R5 result held"}, res, held);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk1("R1 done in reset", done, 1'b0);
        chk17("R1 result in reset", res, 17'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk1("R1 done after reset", done, 1'b0);
        chk17("R1 result after reset", res, 17'd0);

        // table walk: R3, R4, R7, R8 vectors
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][48:33], VEC[v][32:17], VEC[v][16:0], "R3_table", 1'b0);
            n_chk++;
            if (res < ref_mag(VEC[v][48:33], VEC[v][32:17]) ||
                VEC[v][16:0] !== ref_mag(VEC[v][48:33], VEC[v][32:17])) begin
                n_fail++;
                $display("FAIL R7 table/ref mismatch: actual %0d expected %0d",
                         res, ref_mag(VEC[v][48:33], VEC[v][32:17]));
            end
        end

        // directed corners
        run_op(16'h8000, 16'h8000, 17'd45056, "R4 most negative pair", 1'b0);
        run_op(16'd100, 16'd100, 17'd138, "R8 equal magnitudes", 1'b0);
        run_op(16'd3, 16'd4, 17'd5, "R6 R9 busy start and input change", 1'b1);
        run_op(16'h8000, 16'd5, ref_mag(16'h8000, 16'd5), "R9 disturbed corner", 1'b1);

        // R5: no start for several idle cycles keeps the result
        repeat (5) @(posedge clk);
        #1;
        chk17("R5 result kept while idle", res, ref_mag(16'h8000, 16'd5));
        chk1("R5 no spurious done", done, 1'b0);

        // random vectors against the formula of R3
        for (int k = 0; k < 40; k++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            run_op(ra, rb, ref_mag(ra, rb), "R3 random", (k % 5) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule